// File: doc/BRIEF.md
# Modular Halving and Quartering Unit

The unit divides a residue X, taken from [0, p), by two or by four modulo an odd modulus p, and returns the result in [0, p). It does no division. It looks at the low bits of X, and when needed at the low bits of X − p. From those bits it picks a small multiple of p to add or subtract, so that the bits shifted out are zero. It then shifts right. If a subtraction leaves the shifted value negative, one p is added back.

A caller presents X, p and a mode bit together with a valid strobe. The result appears with its own valid strobe one clock later. A small output state machine tracks whether the output register holds a fresh result. It has two states. ST_EMPTY moves to ST_FULL on a cycle with `in_valid` high. ST_FULL stays in ST_FULL on another valid input. ST_FULL returns to ST_EMPTY on a cycle without one. ST_EMPTY stays in ST_EMPTY while no input arrives. A cycle without `in_valid` leaves the result register untouched.

Top module: `mhq_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_res` is 0.
- R2: `out_valid` in any cycle equals `in_valid` of the cycle before, so each result has exactly one cycle of latency.
- R3: With `in_mode` = 0 (halve), `out_res` is the unique value in [0, p) with 2·`out_res` ≡ X (mod p).
- R4: With `in_mode` = 1 (quarter), `out_res` is the unique value in [0, p) with 4·`out_res` ≡ X (mod p), for all four values of X's two low bits.
- R5: When the divisor divides X exactly, in either mode, the result is the plain quotient X/2 or X/4. For X = 0 this gives 0.
- R6: When the quotient is not exact, the result still lies in [0, p). This holds at the edges X = p − 1 and p = 3, and for moduli near 2^N.
- R7: In a cycle with `in_valid` low, `out_res` keeps its previous value, whatever X, p and mode are on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| in_mode | input | 1 | 0 = divide by 2, 1 = divide by 4 |
| in_x | input | N | Residue X, in [0, p) |
| in_p | input | N | Odd modulus p, at least 3 |
| out_valid | output | 1 | `out_res` holds a new result |
| out_res | output | N | X/2 or X/4 modulo p, in [0, p) |

## Verification
The bench builds two copies of the unit.

With N = 4, it sweeps every odd modulus from 3 to 15 against every residue, in both modes. This covers every low-bit pattern of X and of X − p, and every case in which p must be added back.

With N = 16, it drives seeded random odd moduli and residues, plus moduli close to 2^16. These reach the case where 3p nearly fills the widened signed intermediate, which is where a width error would show.

// File: rtl/mhq_pkg.sv
package mhq_pkg;

    typedef enum logic {
        MODE_HALF    = 1'b0,
        MODE_QUARTER = 1'b1
    } div_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    // multiple of p folded into X before the shift
    typedef enum logic [2:0] {
        MUL_ZERO,
        MUL_ADD1,
        MUL_SUB1,
        MUL_SUB2,
        MUL_SUB3
    } mult_e;

endpackage

// File: rtl/mhq_mult_sel.sv
module mhq_mult_sel
    import mhq_pkg::*;
(
    input  div_mode_e  mode,
    input  logic [1:0] x_lo,
    input  logic [1:0] p_lo,
    output mult_e      sel
);
    logic [1:0] diff_lo;

    // low two bits of X - p
    assign diff_lo = x_lo - p_lo;

    always_comb begin
        sel = MUL_ZERO;
        unique case (mode)
            MODE_HALF: begin
                sel = x_lo[0] ? MUL_ADD1 : MUL_ZERO;
            end
            MODE_QUARTER: begin
                unique case (x_lo)
                    2'b00: sel = MUL_ZERO;
                    2'b10: sel = MUL_SUB2;
                    default: sel = (diff_lo == 2'b10) ? MUL_SUB3 : MUL_SUB1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mhq_core.sv
module mhq_core
    import mhq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] p,
    input  div_mode_e    mode,
    input  mult_e        sel,
    output logic [N-1:0] res
);
    localparam int W = N + 3;

    logic signed [W-1:0] xs, ps, p2, p3;
    logic signed [W-1:0] acc, shifted, fixed;

    assign xs = $signed({3'b000, x});
    assign ps = $signed({3'b000, p});
    assign p2 = ps <<< 1;
    assign p3 = ps + p2;

    always_comb begin
        acc = xs;
        unique case (sel)
            MUL_ZERO: acc = xs;
            MUL_ADD1: acc = xs + ps;
            MUL_SUB1: acc = xs - ps;
            MUL_SUB2: acc = xs - p2;
            MUL_SUB3: acc = xs - p3;
            default:  acc = xs;
        endcase
    end

    assign shifted = (mode == MODE_QUARTER) ? (acc >>> 2) : (acc >>> 1);
    assign fixed   = shifted[W-1] ? (shifted + ps) : shifted;
    assign res     = fixed[N-1:0];
endmodule

// File: rtl/mhq_unit.sv
module mhq_unit
    import mhq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_mode,
    input  logic [N-1:0] in_x,
    input  logic [N-1:0] in_p,
    output logic         out_valid,
    output logic [N-1:0] out_res
);
    div_mode_e    mode;
    mult_e        sel;
    logic [N-1:0] comb_res;
    out_state_e   state, state_nx;
    logic [N-1:0] res_q;

    assign mode = div_mode_e'(in_mode);

    mhq_mult_sel sel_i (
        .mode (mode),
        .x_lo (in_x[1:0]),
        .p_lo (in_p[1:0]),
        .sel  (sel)
    );

    mhq_core #(.N(N)) core_i (
        .x    (in_x),
        .p    (in_p),
        .mode (mode),
        .sel  (sel),
        .res  (comb_res)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            res_q <= '0;
        end else begin
            state <= state_nx;
            if (in_valid) res_q <= comb_res;
        end
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        out_res   = res_q;
    end
endmodule

// File: rtl/mhq_unit_chk.sv
module mhq_unit_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_mode,
    input logic [N-1:0] in_x,
    input logic [N-1:0] in_p,
    input logic         out_valid,
    input logic [N-1:0] out_res
);
    logic [N+2:0] res_x2, res_x4;

    assign res_x2 = {3'b000, out_res} << 1;
    assign res_x4 = {3'b000, out_res} << 2;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_res < $past(in_p)));

    // R3
    half_cong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> ((res_x2 % {3'b000, $past(in_p)}) == {3'b000, $past(in_x)}));

    // R4
    quarter_cong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode) |=> ((res_x4 % {3'b000, $past(in_p)}) == {3'b000, $past(in_x)}));

    // R7
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res));
endmodule

bind mhq_unit mhq_unit_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_x      (in_x),
    .in_p      (in_p),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/mhq_unit_tb_top.sv
`timescale 1ns/1ps
module mhq_unit_tb_top;
    localparam int NB = 16;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          b_valid = 1'b0, b_mode = 1'b0;
    logic [NB-1:0] b_x = '0, b_p = 16'd3;
    logic          b_ovalid;
    logic [NB-1:0] b_res;

    logic          s_valid = 1'b0, s_mode = 1'b0;
    logic [NS-1:0] s_x = '0, s_p = 4'd3;
    logic          s_ovalid;
    logic [NS-1:0] s_res;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mhq_unit #(.N(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_mode(b_mode),
        .in_x(b_x), .in_p(b_p), .out_valid(b_ovalid), .out_res(b_res)
    );

    mhq_unit #(.N(NS)) dut_s (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_mode(s_mode),
        .in_x(s_x), .in_p(s_p), .out_valid(s_ovalid), .out_res(s_res)
    );

    // add multiples of p until the divisor goes in exactly
    function automatic longint exp_val(input bit quarter, input longint x, input longint p);
        longint d = quarter ? 4 : 2;
        for (int j = 0; j < 4; j++) begin
            if ((x + j * p) % d == 0) return (x + j * p) / d;
        end
        return -1;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_big(input bit mode, input longint x, input longint p, input string req);
        @(negedge clk);
        b_valid = 1'b1; b_mode = mode; b_x = NB'(x); b_p = NB'(p);
        @(negedge clk);
        b_valid = 1'b0;
        check("R2", longint'(b_ovalid), 1);
        check(req, longint'(b_res), exp_val(mode, x, p));
    endtask

    task automatic run_small(input bit mode, input longint x, input longint p, input string req);
        @(negedge clk);
        s_valid = 1'b1; s_mode = mode; s_x = NS'(x); s_p = NS'(p);
        @(negedge clk);
        s_valid = 1'b0;
        check(req, longint'(s_res), exp_val(mode, x, p));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        longint p, x;
        longint held;
        void'($urandom(32'd1207));
        repeat (3) @(negedge clk);
        // R1
        check("R1", longint'(b_ovalid), 0);
        check("R1", longint'(b_res), 0);
        check("R1", longint'(s_ovalid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 exact quotients and zero
        run_big(1'b0, 0, 65521, "R5");
        run_big(1'b1, 0, 65521, "R5");
        run_big(1'b0, 1000, 65521, "R5");
        check("R5", longint'(b_res), 500);
        run_big(1'b1, 1000, 65521, "R5");
        check("R5", longint'(b_res), 250);

        // R4 each low-bit class of X, including the X-p split
        run_big(1'b1, 6, 11, "R4");
        run_big(1'b1, 5, 11, "R4");
        run_big(1'b1, 7, 11, "R4");
        run_big(1'b1, 3, 13, "R4");
        run_big(1'b1, 1, 13, "R4");

        // R6 edges: X = p-1, p = 3, p near 2^N
        run_big(1'b1, 65534, 65535, "R6");
        run_big(1'b0, 65534, 65535, "R6");
        run_big(1'b1, 65532, 65533, "R6");
        run_big(1'b1, 2, 3, "R6");
        run_big(1'b0, 1, 3, "R6");
        run_big(1'b1, 65535 - 2, 65535, "R6");

        // R7 hold with changing inputs while invalid
        held = longint'(b_res);
        @(negedge clk);
        b_x = 16'd9; b_p = 16'd17; b_mode = 1'b0;
        @(negedge clk);
        check("R7", longint'(b_res), held);
        check("R2", longint'(b_ovalid), 0);

        // R3 / R4 random, both modes
        for (int i = 0; i < 400; i++) begin
            p = longint'($urandom & 32'hFFFF) | 1;
            if (p < 3) p = 3;
            x = longint'($urandom % 32'(p));
            if (i % 2 == 0) run_big(1'b0, x, p, "R3");
            else run_big(1'b1, x, p, "R4");
        end

        // R3 / R4 exhaustive for the narrow copy
        for (int pp = 3; pp < 16; pp += 2) begin
            for (int xx = 0; xx < pp; xx++) begin
                run_small(1'b0, xx, pp, "R3");
                run_small(1'b1, xx, pp, "R4");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule